// File: doc/BRIEF.md
# UART Register Front-End with Split Interrupts

This block puts a 32-bit memory-mapped register view on top of a UART's transmit and receive engines. Software turns each direction on or off through a write-only command word. It reads engine state from a read-only status word and pushes characters through a transmit data port. It pops received characters, together with their error bits, through an extended receive port. The serial engines, the baud generator and pin routing sit outside this block. It only hands them configuration and strobes and takes their state back.

Four interrupt sources are gathered into one flag word. Transmission complete, receive data valid and receive overflow are sticky. Each can be set by writing ones to a set alias and cleared by writing ones to a clear alias. The transmit buffer level source is live and needs no clearing. An enable word gates the flags. The receive-side sources drive one interrupt line and the transmit-side sources drive a second, so a host can service the two directions from separate handlers.

Top module: `uart_csr_top`

## Requirements
- R1: After reset, both direction enables, both interrupt lines, the sticky flags, the enable word, the stored configuration and `bus_rdata` are all zero.
- R2: A write to the command word (offset 0x0C) works per direction. Bit 0 enables receive, bit 1 disables receive, bit 2 enables transmit and bit 3 disables transmit. When enable and disable for one direction are both set, disable wins. A direction whose two bits are zero keeps its state.
- R3: The status word (offset 0x10) shows the transmit enable in bit 1, `tx_idle` in bit 5, transmit buffer room in bit 6 and `rx_avail` in bit 7. All other bits read zero.
- R4: With control bit 12 clear, buffer room means `tx_level` is at most half of `TXBUF_DEPTH`. With bit 12 set, it means `tx_level` is zero.
- R5: The flag word (offset 0x40) holds transmission complete in bit 0, buffer room in bit 1, receive data valid in bit 2 and receive overflow in bit 4. Bit 1 always equals the live room state, and writes to the set or clear alias have no effect on it.
- R6: Writing ones to offset 0x44 sets the matching sticky flags. Writing ones to offset 0x48 clears them. Zero bits have no effect. The pulses `tx_done`, `rx_got` and `rx_ovf` set bits 0, 2 and 4.
- R7: A hardware event that arrives in the same cycle as a clear of its flag leaves the flag set.
- R8: `irq_rx` is high when flag bit 2 or flag bit 4 is set together with the same bit of the enable word (offset 0x4C). `irq_tx` does the same for bits 0 and 1.
- R9: A write to offset 0x34 raises `tx_push` for exactly one cycle in the next cycle. During that cycle `tx_char` carries the low `CHAR_W` bits of the write data.
- R10: A read of offset 0x18 returns `rx_char` in the low `CHAR_W` bits, `rx_perr` in bit 14 and `rx_ferr` in bit 15. `rx_pop` is raised for exactly one cycle, the same cycle the data appears.
- R11: The control word (offset 0x00) keeps only bit 0 (`sync_mode`) and bit 12 (`tx_empty_level`). The frame word (offset 0x04) keeps its low `FRAME_W` bits and the divider (offset 0x14) keeps its low `DIV_W` bits. All three read back what they kept.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` and is zero in every other cycle. The write-only offsets (0x0C, 0x34, 0x44, 0x48) and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request for one cycle |
| bus_rd | input | 1 | Read request for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| rx_enable | output | 1 | Receive engine enable |
| tx_enable | output | 1 | Transmit engine enable |
| sync_mode | output | 1 | Synchronous mode select from control bit 0 |
| tx_empty_level | output | 1 | Buffer-level meaning select from control bit 12 |
| frame_cfg | output | FRAME_W | Stored frame format word |
| clk_div | output | DIV_W | Stored clock divider |
| tx_push | output | 1 | Strobe that loads a character into the transmit buffer |
| tx_char | output | CHAR_W | Character for the transmit buffer |
| tx_level | input | $clog2(TXBUF_DEPTH+1) | Transmit buffer occupancy |
| tx_done | input | 1 | Pulse when a transmission finishes with nothing left |
| tx_idle | input | 1 | Transmitter has nothing left to send |
| rx_char | input | CHAR_W | Oldest received character |
| rx_perr | input | 1 | Parity error of that character |
| rx_ferr | input | 1 | Framing error of that character |
| rx_avail | input | 1 | At least one received character is waiting |
| rx_got | input | 1 | Pulse when a new character arrives |
| rx_ovf | input | 1 | Pulse when a received character was lost |
| rx_pop | output | 1 | Strobe that removes the oldest received character |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The assertions rely on a few promises about the inputs. `bus_wr` and `bus_rd` are never both high in one cycle. `tx_done`, `rx_got` and `rx_ovf` are single-cycle pulses. `tx_level` never exceeds `TXBUF_DEPTH`. The stimulus keeps to these promises because every input change is made by a task, one transaction at a time, and each task drops its pulse on the following falling edge. The engine-side levels are changed only between bus transactions, so every check sees a settled state.

// File: rtl/uart_csr_pkg.sv
// Package: uart_csr_pkg
// Shared register offsets, bit positions and the register-select type
// for the UART register front-end. Assumes byte offsets fit in 8 bits.
package uart_csr_pkg;

    typedef logic [7:0] reg_off_t;

    // Register byte offsets
    localparam reg_off_t OFF_CTRL   = 8'h00;
    localparam reg_off_t OFF_FRAME  = 8'h04;
    localparam reg_off_t OFF_CMD    = 8'h0C;
    localparam reg_off_t OFF_STATUS = 8'h10;
    localparam reg_off_t OFF_CLKDIV = 8'h14;
    localparam reg_off_t OFF_RXEXT  = 8'h18;
    localparam reg_off_t OFF_TXDATA = 8'h34;
    localparam reg_off_t OFF_IFLAG  = 8'h40;
    localparam reg_off_t OFF_IFSET  = 8'h44;
    localparam reg_off_t OFF_IFCLR  = 8'h48;
    localparam reg_off_t OFF_IEN    = 8'h4C;

    // Command word bit positions
    localparam int CMD_RXON  = 0;
    localparam int CMD_RXOFF = 1;
    localparam int CMD_TXON  = 2;
    localparam int CMD_TXOFF = 3;
    localparam int CMD_W     = 4;

    // Status word bit positions
    localparam int ST_TXON    = 1;
    localparam int ST_TXIDLE  = 5;
    localparam int ST_TXROOM  = 6;
    localparam int ST_RXAVAIL = 7;

    // Interrupt flag bit positions
    localparam int IF_TXC  = 0;
    localparam int IF_TXBL = 1;
    localparam int IF_RXDV = 2;
    localparam int IF_RXOF = 4;
    localparam int FLAG_W  = 5;

    // Control word bit positions
    localparam int CTRL_SYNC     = 0;
    localparam int CTRL_EMPTYLVL = 12;

    // Extended receive word error bit positions
    localparam int RXEXT_PERR = 14;
    localparam int RXEXT_FERR = 15;

    // Flags that hold until cleared, and the split between the two lines
    localparam logic [FLAG_W-1:0] STICKY_MASK = 5'b10101;
    localparam logic [FLAG_W-1:0] RX_SIDE     = 5'b10100;
    localparam logic [FLAG_W-1:0] TX_SIDE     = 5'b00011;
    localparam logic [FLAG_W-1:0] IMPL_MASK   = 5'b10111;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_FRAME,
        SEL_CMD,
        SEL_STATUS,
        SEL_CLKDIV,
        SEL_RXEXT,
        SEL_TXDATA,
        SEL_IFLAG,
        SEL_IFSET,
        SEL_IFCLR,
        SEL_IEN
    } reg_sel_e;

endpackage

// File: rtl/uart_csr_decode.sv
// Module: uart_csr_decode
// Maps a bus byte offset onto one register select. Any offset that is not
// mapped gives SEL_NONE. Purely combinational, and assumes ADDR_W >= 8.
module uart_csr_decode #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]         addr,
    output uart_csr_pkg::reg_sel_e    sel
);
    import uart_csr_pkg::*;

    // Compare the full address against each known offset
    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_CTRL):   sel = SEL_CTRL;
            ADDR_W'(OFF_FRAME):  sel = SEL_FRAME;
            ADDR_W'(OFF_CMD):    sel = SEL_CMD;
            ADDR_W'(OFF_STATUS): sel = SEL_STATUS;
            ADDR_W'(OFF_CLKDIV): sel = SEL_CLKDIV;
            ADDR_W'(OFF_RXEXT):  sel = SEL_RXEXT;
            ADDR_W'(OFF_TXDATA): sel = SEL_TXDATA;
            ADDR_W'(OFF_IFLAG):  sel = SEL_IFLAG;
            ADDR_W'(OFF_IFSET):  sel = SEL_IFSET;
            ADDR_W'(OFF_IFCLR):  sel = SEL_IFCLR;
            ADDR_W'(OFF_IEN):    sel = SEL_IEN;
            default:             sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/uart_csr_cmd.sv
// Module: uart_csr_cmd
// Holds the receive and transmit enable state, driven by command-word
// writes. For each direction a disable bit overrides an enable bit in the
// same write. Assumes cmd_we is a single-cycle write strobe.
module uart_csr_cmd (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_we,
    input  logic [uart_csr_pkg::CMD_W-1:0] cmd_bits,
    output logic                          rx_en,
    output logic                          tx_en
);
    import uart_csr_pkg::*;

    // Receive enable: the disable bit is tested first
    always_ff @(posedge clk) begin
        if (!rst_n)                          rx_en <= 1'b0;
        else if (cmd_we && cmd_bits[CMD_RXOFF]) rx_en <= 1'b0;
        else if (cmd_we && cmd_bits[CMD_RXON])  rx_en <= 1'b1;
    end

    // Transmit enable: the disable bit is tested first
    always_ff @(posedge clk) begin
        if (!rst_n)                          tx_en <= 1'b0;
        else if (cmd_we && cmd_bits[CMD_TXOFF]) tx_en <= 1'b0;
        else if (cmd_we && cmd_bits[CMD_TXON])  tx_en <= 1'b1;
    end

    AST_CMD_TXOFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_bits[CMD_TXOFF]) |=> !tx_en); // R2
    AST_CMD_RXOFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_bits[CMD_RXOFF]) |=> !rx_en); // R2
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> ($stable(tx_en) && $stable(rx_en))); // R2

endmodule

// File: rtl/uart_csr_irq.sv
// Module: uart_csr_irq
// Interrupt flags, enable word and the two interrupt lines. The sticky
// flags are set by engine pulses or by set-alias writes and are cleared by
// clear-alias writes; an engine pulse beats a clear in the same cycle.
// The buffer-level flag is the live room signal and is never stored.
// Assumes set_we and clr_we are never high together.
module uart_csr_irq (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_we,
    input  logic                            clr_we,
    input  logic                            ien_we,
    input  logic [uart_csr_pkg::FLAG_W-1:0] wbits,
    input  logic                            tx_done,
    input  logic                            rx_got,
    input  logic                            rx_ovf,
    input  logic                            room,
    output logic [uart_csr_pkg::FLAG_W-1:0] iflag,
    output logic [uart_csr_pkg::FLAG_W-1:0] ien,
    output logic                            irq_rx,
    output logic                            irq_tx
);
    import uart_csr_pkg::*;

    logic [FLAG_W-1:0] hw_evt;

    // Line up the engine pulses with their flag positions
    always_comb begin
        hw_evt          = '0;
        hw_evt[IF_TXC]  = tx_done;
        hw_evt[IF_RXDV] = rx_got;
        hw_evt[IF_RXOF] = rx_ovf;
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (STICKY_MASK[i]) begin : g_sticky
            logic q;
            // Sticky flag: engine event first, then set alias, then clear alias
            always_ff @(posedge clk) begin
                if (!rst_n)                  q <= 1'b0;
                else if (hw_evt[i])          q <= 1'b1;
                else if (set_we && wbits[i]) q <= 1'b1;
                else if (clr_we && wbits[i]) q <= 1'b0;
            end
            assign iflag[i] = q;
        end else if (i == IF_TXBL) begin : g_level
            assign iflag[i] = room;
        end else begin : g_none
            assign iflag[i] = 1'b0;
        end
    end

    // Enable word keeps only implemented flag positions
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (ien_we) ien <= wbits & IMPL_MASK;
    end

    // Split the enabled flags onto the receive and transmit lines
    always_comb begin
        irq_rx = |(iflag & ien & RX_SIDE);
        irq_tx = |(iflag & ien & TX_SIDE);
    end

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> iflag[IF_RXOF]); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wbits[IF_TXC] && !tx_done) |=> !iflag[IF_TXC]); // R6
    AST_IRQ_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (|(ien & TX_SIDE))); // R8
    AST_IRQ_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (|(ien & RX_SIDE))); // R8
    AST_NO_SET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we && clr_we)); // R6

endmodule

// File: rtl/uart_csr_rdmux.sv
// Module: uart_csr_rdmux
// Registered read path. It returns the selected word one cycle after the
// read request and zero otherwise. A read of the extended receive port
// raises rx_pop in the cycle the data is presented.
module uart_csr_rdmux #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  uart_csr_pkg::reg_sel_e     sel,
    input  logic [DATA_W-1:0]          ctrl_word,
    input  logic [DATA_W-1:0]          frame_word,
    input  logic [DATA_W-1:0]          status_word,
    input  logic [DATA_W-1:0]          clkdiv_word,
    input  logic [DATA_W-1:0]          rxext_word,
    input  logic [DATA_W-1:0]          iflag_word,
    input  logic [DATA_W-1:0]          ien_word,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rx_pop
);
    import uart_csr_pkg::*;

    logic [DATA_W-1:0] mux_word;

    // Choose the readable word; write-only and unmapped give zero
    always_comb begin
        unique case (sel)
            SEL_CTRL:   mux_word = ctrl_word;
            SEL_FRAME:  mux_word = frame_word;
            SEL_STATUS: mux_word = status_word;
            SEL_CLKDIV: mux_word = clkdiv_word;
            SEL_RXEXT:  mux_word = rxext_word;
            SEL_IFLAG:  mux_word = iflag_word;
            SEL_IEN:    mux_word = ien_word;
            default:    mux_word = '0;
        endcase
    end

    // Capture read data and the pop strobe on the request edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rx_pop <= 1'b0;
        end else begin
            rdata  <= rd_en ? mux_word : '0;
            rx_pop <= rd_en && (sel == SEL_RXEXT);
        end
    end

    AST_POP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(rd_en)); // R10
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !$past(rd_en, 1)) |-> 1'b0); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0)); // R12

endmodule

// File: rtl/uart_csr_top.sv
// Module: uart_csr_top
// Memory-mapped register front-end for a UART: control, frame and divider
// storage, a command word for the direction enables, a status word, a
// transmit data port, an extended receive port, and interrupt flags with
// set and clear aliases feeding separate receive and transmit lines.
// Assumes bus_wr and bus_rd are never high together, DATA_W >= 16, and
// tx_level never exceeds TXBUF_DEPTH.
module uart_csr_top #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CHAR_W      = 9,
    parameter int FRAME_W     = 16,
    parameter int DIV_W       = 15,
    parameter int TXBUF_DEPTH = 2,
    localparam int LVL_W      = $clog2(TXBUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              sync_mode,
    output logic              tx_empty_level,
    output logic [FRAME_W-1:0] frame_cfg,
    output logic [DIV_W-1:0]  clk_div,
    output logic              tx_push,
    output logic [CHAR_W-1:0] tx_char,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              tx_done,
    input  logic              tx_idle,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_avail,
    input  logic              rx_got,
    input  logic              rx_ovf,
    output logic              rx_pop,
    output logic              irq_rx,
    output logic              irq_tx
);
    import uart_csr_pkg::*;

    localparam int HALF_LVL = TXBUF_DEPTH / 2;

    reg_sel_e          sel;
    logic              we_ctrl, we_frame, we_cmd, we_clkdiv, we_tx;
    logic              we_ifs, we_ifc, we_ien;
    logic              room;
    logic [FLAG_W-1:0] iflag, ien;
    logic [DATA_W-1:0] ctrl_word, frame_word, status_word, clkdiv_word;
    logic [DATA_W-1:0] rxext_word, iflag_word, ien_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    uart_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Per-register write strobes
    always_comb begin
        we_ctrl   = bus_wr && (sel == SEL_CTRL);
        we_frame  = bus_wr && (sel == SEL_FRAME);
        we_cmd    = bus_wr && (sel == SEL_CMD);
        we_clkdiv = bus_wr && (sel == SEL_CLKDIV);
        we_tx     = bus_wr && (sel == SEL_TXDATA);
        we_ifs    = bus_wr && (sel == SEL_IFSET);
        we_ifc    = bus_wr && (sel == SEL_IFCLR);
        we_ien    = bus_wr && (sel == SEL_IEN);
    end

    // Control bits: synchronous mode and buffer-level meaning
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_mode      <= 1'b0;
            tx_empty_level <= 1'b0;
        end else if (we_ctrl) begin
            sync_mode      <= bus_wdata[CTRL_SYNC];
            tx_empty_level <= bus_wdata[CTRL_EMPTYLVL];
        end
    end

    // Frame format and clock divider storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cfg <= '0;
            clk_div   <= '0;
        end else begin
            if (we_frame)  frame_cfg <= bus_wdata[FRAME_W-1:0];
            if (we_clkdiv) clk_div   <= bus_wdata[DIV_W-1:0];
        end
    end

    // One-cycle push strobe with the character for the transmit buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_push <= 1'b0;
            tx_char <= '0;
        end else begin
            tx_push <= we_tx;
            if (we_tx) tx_char <= bus_wdata[CHAR_W-1:0];
        end
    end

    uart_csr_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (we_cmd),
        .cmd_bits (bus_wdata[CMD_W-1:0]),
        .rx_en    (rx_enable),
        .tx_en    (tx_enable)
    );

    // Buffer room: empty in empty-level mode, else at most half full
    always_comb begin
        if (tx_empty_level) room = (tx_level == '0);
        else                room = (tx_level <= LVL_W'(HALF_LVL));
    end

    uart_csr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (we_ifs),
        .clr_we  (we_ifc),
        .ien_we  (we_ien),
        .wbits   (bus_wdata[FLAG_W-1:0]),
        .tx_done (tx_done),
        .rx_got  (rx_got),
        .rx_ovf  (rx_ovf),
        .room    (room),
        .iflag   (iflag),
        .ien     (ien),
        .irq_rx  (irq_rx),
        .irq_tx  (irq_tx)
    );

    // Assemble the readable words
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_SYNC]     = sync_mode;
        ctrl_word[CTRL_EMPTYLVL] = tx_empty_level;
        frame_word               = DATA_W'(frame_cfg);
        clkdiv_word              = DATA_W'(clk_div);
        status_word              = '0;
        status_word[ST_TXON]     = tx_enable;
        status_word[ST_TXIDLE]   = tx_idle;
        status_word[ST_TXROOM]   = room;
        status_word[ST_RXAVAIL]  = rx_avail;
        rxext_word               = '0;
        rxext_word[CHAR_W-1:0]   = rx_char;
        rxext_word[RXEXT_PERR]   = rx_perr;
        rxext_word[RXEXT_FERR]   = rx_ferr;
        iflag_word               = DATA_W'(iflag);
        ien_word                 = DATA_W'(ien);
    end

    uart_csr_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (bus_rd),
        .sel         (sel),
        .ctrl_word   (ctrl_word),
        .frame_word  (frame_word),
        .status_word (status_word),
        .clkdiv_word (clkdiv_word),
        .rxext_word  (rxext_word),
        .iflag_word  (iflag_word),
        .ien_word    (ien_word),
        .rdata       (bus_rdata),
        .rx_pop      (rx_pop)
    );

    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R12
    AST_PUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(bus_wr)); // R9
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(TXBUF_DEPTH)); // R4

endmodule

// File: tb/uart_csr_top_tb.sv
// Directed testbench for uart_csr_top: one task per scenario, each
// task checking its own results at the ports.
module uart_csr_top_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CHAR_W = 9;
    localparam int LVL_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              rx_enable, tx_enable, sync_mode, tx_empty_level;
    logic [15:0]       frame_cfg;
    logic [14:0]       clk_div;
    logic              tx_push;
    logic [CHAR_W-1:0] tx_char;
    logic [LVL_W-1:0]  tx_level = '0;
    logic              tx_done = 1'b0, tx_idle = 1'b1;
    logic [CHAR_W-1:0] rx_char = '0;
    logic              rx_perr = 1'b0, rx_ferr = 1'b0, rx_avail = 1'b0;
    logic              rx_got = 1'b0, rx_ovf = 1'b0;
    logic              rx_pop, irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] rd;

    always #5 clk = ~clk;

    uart_csr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_enable(rx_enable), .tx_enable(tx_enable), .sync_mode(sync_mode),
        .tx_empty_level(tx_empty_level), .frame_cfg(frame_cfg), .clk_div(clk_div),
        .tx_push(tx_push), .tx_char(tx_char), .tx_level(tx_level),
        .tx_done(tx_done), .tx_idle(tx_idle), .rx_char(rx_char),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_avail(rx_avail),
        .rx_got(rx_got), .rx_ovf(rx_ovf), .rx_pop(rx_pop),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        check(rx_enable == 0 && tx_enable == 0, "R1 enables", {rx_enable, tx_enable}, 0);
        check(irq_rx == 0 && irq_tx == 0, "R1 irqs", {irq_rx, irq_tx}, 0);
        check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        bus_read(8'h00, rd); check(rd == 0, "R1 ctrl", rd, 0);
        bus_read(8'h4C, rd); check(rd == 0, "R1 ien", rd, 0);
        bus_read(8'h40, rd); check(rd == 32'h2, "R1 flags only live room", rd, 32'h2);
    endtask

    task automatic t_cmd();
        bus_write(8'h0C, 32'h5);
        check(rx_enable && tx_enable, "R2 enable both", {rx_enable, tx_enable}, 3);
        bus_write(8'h0C, 32'h0);
        check(rx_enable && tx_enable, "R2 zero keeps", {rx_enable, tx_enable}, 3);
        bus_write(8'h0C, 32'hC);
        check(!tx_enable && rx_enable, "R2 tx off wins", {rx_enable, tx_enable}, 2);
        bus_write(8'h0C, 32'h3);
        check(!rx_enable, "R2 rx off wins", rx_enable, 0);
        bus_write(8'h0C, 32'h4);
        bus_read(8'h10, rd);
        check(rd == 32'h62, "R3 status tx on", rd, 32'h62);
    endtask

    task automatic t_status();
        tx_level = 2; tx_idle = 1'b0; rx_avail = 1'b1;
        bus_read(8'h10, rd); check(rd == 32'h82, "R3 status busy", rd, 32'h82);
        tx_level = 1;
        bus_read(8'h10, rd); check(rd == 32'hC2, "R4 half mode room", rd, 32'hC2);
        bus_write(8'h00, 32'h1000);
        bus_read(8'h10, rd); check(rd == 32'h82, "R4 empty mode no room", rd, 32'h82);
        tx_level = 0;
        bus_read(8'h10, rd); check(rd == 32'hC2, "R4 empty mode room", rd, 32'hC2);
        bus_write(8'h00, 32'h0);
        tx_idle = 1'b1; rx_avail = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_done = 1'b1;
            1: rx_got = 1'b1;
            default: rx_ovf = 1'b1;
        endcase
        @(negedge clk);
        tx_done = 1'b0; rx_got = 1'b0; rx_ovf = 1'b0;
    endtask

    task automatic t_flags();
        pulse(0);
        bus_read(8'h40, rd); check(rd == 32'h3, "R6 txc set by event", rd, 32'h3);
        bus_write(8'h48, 32'h1);
        bus_read(8'h40, rd); check(rd == 32'h2, "R6 clear alias", rd, 32'h2);
        bus_write(8'h44, 32'h14);
        bus_read(8'h40, rd); check(rd == 32'h16, "R6 set alias", rd, 32'h16);
        bus_write(8'h48, 32'h2);
        bus_read(8'h40, rd); check(rd == 32'h16, "R5 clear ignores level bit", rd, 32'h16);
        tx_level = 2;
        bus_write(8'h44, 32'h2);
        bus_read(8'h40, rd); check(rd == 32'h14, "R5 set ignores level bit", rd, 32'h14);
        tx_level = 0;
        bus_write(8'h48, 32'h1F);
        bus_read(8'h40, rd); check(rd == 32'h2, "R6 clear all", rd, 32'h2);
    endtask

    task automatic t_race();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h10; rx_ovf = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; rx_ovf = 1'b0;
        bus_read(8'h40, rd); check(rd[4] == 1'b1, "R7 event beats clear", rd, 32'h12);
        bus_write(8'h48, 32'h10);
    endtask

    task automatic t_irq();
        bus_write(8'h4C, 32'h4);
        check(irq_rx == 0 && irq_tx == 0, "R8 nothing pending", {irq_rx, irq_tx}, 0);
        pulse(1);
        check(irq_rx == 1 && irq_tx == 0, "R8 rx line", {irq_rx, irq_tx}, 2);
        bus_write(8'h4C, 32'h2);
        check(irq_rx == 0 && irq_tx == 1, "R8 tx line from room", {irq_rx, irq_tx}, 1);
        tx_level = 2;
        @(negedge clk);
        check(irq_tx == 0, "R8 tx line drops with room", irq_tx, 0);
        tx_level = 0;
        bus_write(8'h4C, 32'h10);
        pulse(2);
        check(irq_rx == 1, "R8 overflow on rx line", irq_rx, 1);
        bus_write(8'h48, 32'h1F);
        check(irq_rx == 0, "R8 rx line after clear", irq_rx, 0);
        bus_write(8'h4C, 32'h0);
    endtask

    task automatic t_tx();
        bus_write(8'h34, 32'hFFFF_F1A5);
        check(tx_push == 1 && tx_char == 9'h1A5, "R9 push with char", {tx_push, tx_char}, 32'h3A5);
        @(negedge clk);
        check(tx_push == 0, "R9 push one cycle", tx_push, 0);
    endtask

    task automatic t_rx();
        rx_char = 9'h0F3; rx_perr = 1'b1; rx_ferr = 1'b0;
        bus_read(8'h18, rd);
        check(rd == 32'h40F3, "R10 rx word", rd, 32'h40F3);
        check(rx_pop == 1, "R10 pop with data", rx_pop, 1);
        @(negedge clk);
        check(rx_pop == 0, "R10 pop one cycle", rx_pop, 0);
        rx_perr = 1'b0; rx_ferr = 1'b1; rx_char = 9'h100;
        bus_read(8'h18, rd);
        check(rd == 32'h8100, "R10 framing bit", rd, 32'h8100);
        rx_ferr = 1'b0;
    endtask

    task automatic t_cfg();
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, rd);
        check(rd == 32'h1001 && sync_mode && tx_empty_level, "R11 ctrl mask", rd, 32'h1001);
        bus_write(8'h04, 32'h1234_5678);
        bus_read(8'h04, rd);
        check(rd == 32'h5678 && frame_cfg == 16'h5678, "R11 frame", rd, 32'h5678);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, rd);
        check(rd == 32'h7FFF && clk_div == 15'h7FFF, "R11 divider", rd, 32'h7FFF);
        bus_read(8'h0C, rd); check(rd == 0, "R12 cmd reads zero", rd, 0);
        bus_read(8'h20, rd); check(rd == 0, "R12 unmapped zero", rd, 0);
        @(negedge clk);
        check(bus_rdata == 0, "R12 zero without read", bus_rdata, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd();
        t_status();
        t_flags();
        t_race();
        t_irq();
        t_tx();
        t_rx();
        t_cfg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule